// File: doc/BRIEF.md
# Processor Status Byte with Interrupt Gating

This block keeps the processor's eight-bit status byte and decides when an interrupt request is accepted. The byte holds a two-bit paging mode, a register-bank select bit, carry, zero and a global interrupt enable. Two bits are reserved and always read as zero. Software changes the byte only through immediate AND, OR and XOR operations. The arithmetic unit updates carry and zero through their own write enables. The return-from-interrupt path reloads the whole byte.

An interrupt request is sampled only when an instruction completes, and only while the interrupt enable is set. When a request is accepted, the block captures the status byte, with the enable still set, for the stack. On that same edge it clears the enable, which blocks nested interrupts. The byte can be read over the register bus at a fixed address, whichever bank is selected. The paging mode and the bank select bit are driven out for use by neighbouring logic.

Top module: `status_flag_unit`

## Requirements
- R1: After reset the status byte is 0x02: only zero is set. The accept pulse is low, bank select is 0 and paging mode is 0.
- R2: On a clock edge, `fop_i` applies an operation with `fop_imm_i` to the byte. The encodings are 2'b00 none, 2'b01 AND, 2'b10 OR and 2'b11 XOR.
- R3: Bits 5 and 3 of the byte are always 0. This holds after a logic operation, after a restore, on the register-bus read and on the stacked copy.
- R4: Carry is bit 2 and is loaded from `alu_c_i` when `alu_c_we_i` is high. Zero is bit 1 and is loaded from `alu_z_i` when `alu_z_we_i` is high. Each enable touches only its own bit.
- R5: When a logic operation and an arithmetic update arrive in the same cycle, the logic operation alone sets the byte.
- R6: Suppose `insn_end_i` and `irq_i` are high on an edge while the enable (bit 0) is 1. After that edge `irq_take_o` is high for exactly one cycle. `stack_flags_o` then holds the byte as it was before the edge, and bit 0 of the byte is 0.
- R7: A request is ignored while the enable is 0. It is also ignored when `insn_end_i` is low.
- R8: An accepted interrupt takes priority over a logic operation, an arithmetic update and a restore in the same cycle. Those are discarded, and only the enable is cleared.
- R9: `restore_we_i` loads `restore_i` with bits 5 and 3 forced to 0. A restore takes priority over a logic operation and an arithmetic update in the same cycle.
- R10: When `rd_en_i` is high and `rd_addr_i` is 0xF7, `rd_hit_o` is 1 and `rd_data_o` carries the byte, whatever the bank select bit is. For any other address, or with `rd_en_i` low, both outputs are 0.
- R11: `bank_sel_o` follows bit 4 of the byte. `page_mode_o` follows bits 7:6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fop_i | input | 2 | Logic operation select |
| fop_imm_i | input | 8 | Immediate operand |
| alu_c_we_i | input | 1 | Carry write enable |
| alu_c_i | input | 1 | New carry value |
| alu_z_we_i | input | 1 | Zero write enable |
| alu_z_i | input | 1 | New zero value |
| restore_we_i | input | 1 | Full byte reload strobe |
| restore_i | input | 8 | Byte to reload |
| rd_en_i | input | 1 | Register-bus read strobe |
| rd_addr_i | input | 8 | Register-bus address |
| rd_data_o | output | 8 | Read data |
| rd_hit_o | output | 1 | Address matched |
| irq_i | input | 1 | Interrupt request |
| insn_end_i | input | 1 | Instruction boundary strobe |
| irq_take_o | output | 1 | Interrupt accepted pulse |
| stack_flags_o | output | 8 | Byte captured for stacking |
| flags_o | output | 8 | Current status byte |
| bank_sel_o | output | 1 | Register bank select |
| page_mode_o | output | 2 | Paging mode |

## Verification
The assertions check on every cycle that the reserved bits stay zero. They also check that an accept pulse never lasts two cycles, that the enable is clear after every accept, and that the stacked copy always shows the enable set. A further assertion checks that a request is never accepted while the enable is low. The bench scenarios are needed for the rest: the result of each logic operation, the priority among accept, restore, logic operation and arithmetic update, the read decode at and away from 0xF7 with either bank, and the exact stacked byte value.

// File: rtl/status_flag_pkg.sv
package status_flag_pkg;
  localparam int unsigned FLAG_W   = 8;
  localparam int unsigned BIT_GIE  = 0;
  localparam int unsigned BIT_Z    = 1;
  localparam int unsigned BIT_C    = 2;
  localparam int unsigned BIT_BANK = 4;
  localparam int unsigned BIT_PG_L = 6;
  localparam logic [FLAG_W-1:0] RSVD_MASK = 8'h28;
  localparam logic [FLAG_W-1:0] RST_VAL   = 8'h02;

  typedef enum logic [1:0] {
    FOP_NONE = 2'b00,
    FOP_AND  = 2'b01,
    FOP_OR   = 2'b10,
    FOP_XOR  = 2'b11
  } flag_op_e;
endpackage

// File: rtl/flag_next.sv
module flag_next
  import status_flag_pkg::*;
(
  input  logic [FLAG_W-1:0] cur_i,
  input  flag_op_e          op_i,
  input  logic [FLAG_W-1:0] imm_i,
  input  logic              alu_c_we_i,
  input  logic              alu_c_i,
  input  logic              alu_z_we_i,
  input  logic              alu_z_i,
  input  logic              restore_we_i,
  input  logic [FLAG_W-1:0] restore_i,
  input  logic              take_i,
  output logic [FLAG_W-1:0] nxt_o
);
  logic [FLAG_W-1:0] raw;

  // priority: take > restore > logic op > alu
  always_comb begin
    raw = cur_i;
    if (take_i) begin
      raw[BIT_GIE] = 1'b0;
    end else if (restore_we_i) begin
      raw = restore_i;
    end else if (op_i != FOP_NONE) begin
      unique case (op_i)
        FOP_AND: raw = cur_i & imm_i;
        FOP_OR:  raw = cur_i | imm_i;
        FOP_XOR: raw = cur_i ^ imm_i;
        default: raw = cur_i;
      endcase
    end else begin
      if (alu_c_we_i) raw[BIT_C] = alu_c_i;
      if (alu_z_we_i) raw[BIT_Z] = alu_z_i;
    end
    nxt_o = raw & ~RSVD_MASK;
  end
endmodule

// File: rtl/irq_gate.sv
module irq_gate
  import status_flag_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              irq_i,
  input  logic              insn_end_i,
  input  logic [FLAG_W-1:0] flags_i,
  output logic              take_now_o,
  output logic              take_o,
  output logic [FLAG_W-1:0] stack_o
);
  assign take_now_o = irq_i & insn_end_i & flags_i[BIT_GIE];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      take_o  <= 1'b0;
      stack_o <= '0;
    end else begin
      take_o <= take_now_o;
      if (take_now_o) stack_o <= flags_i;
    end
  end

  // R6
  take_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |=> !take_o);
  // R6
  stack_gie_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> stack_o[BIT_GIE]);
  // R7
  gated_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_i && insn_end_i && !flags_i[BIT_GIE]) |=> !take_o);
endmodule

// File: rtl/flag_rd_port.sv
module flag_rd_port
  import status_flag_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'hF7
) (
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic [FLAG_W-1:0] flags_i,
  output logic              hit_o,
  output logic [FLAG_W-1:0] data_o
);
  // decode ignores bank select
  assign hit_o  = rd_en_i && (rd_addr_i == REG_ADDR);
  assign data_o = hit_o ? (flags_i & ~RSVD_MASK) : '0;
endmodule

// File: rtl/status_flag_unit.sv
module status_flag_unit
  import status_flag_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'hF7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        fop_i,
  input  logic [7:0]        fop_imm_i,
  input  logic              alu_c_we_i,
  input  logic              alu_c_i,
  input  logic              alu_z_we_i,
  input  logic              alu_z_i,
  input  logic              restore_we_i,
  input  logic [7:0]        restore_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [7:0]        rd_data_o,
  output logic              rd_hit_o,
  input  logic              irq_i,
  input  logic              insn_end_i,
  output logic              irq_take_o,
  output logic [7:0]        stack_flags_o,
  output logic [7:0]        flags_o,
  output logic              bank_sel_o,
  output logic [1:0]        page_mode_o
);
  logic [FLAG_W-1:0] flags_q, flags_d;
  logic              take_now;

  irq_gate u_gate (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .irq_i      (irq_i),
    .insn_end_i (insn_end_i),
    .flags_i    (flags_q),
    .take_now_o (take_now),
    .take_o     (irq_take_o),
    .stack_o    (stack_flags_o)
  );

  flag_next u_next (
    .cur_i        (flags_q),
    .op_i         (flag_op_e'(fop_i)),
    .imm_i        (fop_imm_i),
    .alu_c_we_i   (alu_c_we_i),
    .alu_c_i      (alu_c_i),
    .alu_z_we_i   (alu_z_we_i),
    .alu_z_i      (alu_z_i),
    .restore_we_i (restore_we_i),
    .restore_i    (restore_i),
    .take_i       (take_now),
    .nxt_o        (flags_d)
  );

  flag_rd_port #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_rd (
    .rd_en_i   (rd_en_i),
    .rd_addr_i (rd_addr_i),
    .flags_i   (flags_q),
    .hit_o     (rd_hit_o),
    .data_o    (rd_data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_q <= RST_VAL;
    else         flags_q <= flags_d;
  end

  assign flags_o     = flags_q;
  assign bank_sel_o  = flags_q[BIT_BANK];
  assign page_mode_o = flags_q[BIT_PG_L+1:BIT_PG_L];

  // R3
  rsvd_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flags_q & RSVD_MASK) == '0);
  // R6
  gie_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_take_o |-> !flags_q[BIT_GIE]);
  // R3
  stack_rsvd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stack_flags_o & RSVD_MASK) == '0);
endmodule

// File: tb/status_flag_unit_tb.sv
module status_flag_unit_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] fop = 2'b00;
  logic [7:0] imm = '0;
  logic       c_we = 0, c_v = 0, z_we = 0, z_v = 0;
  logic       rs_we = 0;
  logic [7:0] rs_v = '0;
  logic       rd_en = 0;
  logic [7:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       rd_hit;
  logic       irq = 0, iend = 0;
  logic       take;
  logic [7:0] stk, flags;
  logic       bank;
  logic [1:0] pg;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  status_flag_unit u_dut (
    .clk_i(clk), .rst_ni(rst_n), .fop_i(fop), .fop_imm_i(imm),
    .alu_c_we_i(c_we), .alu_c_i(c_v), .alu_z_we_i(z_we), .alu_z_i(z_v),
    .restore_we_i(rs_we), .restore_i(rs_v), .rd_en_i(rd_en), .rd_addr_i(rd_addr),
    .rd_data_o(rd_data), .rd_hit_o(rd_hit), .irq_i(irq), .insn_end_i(iend),
    .irq_take_o(take), .stack_flags_o(stk), .flags_o(flags),
    .bank_sel_o(bank), .page_mode_o(pg)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle();
    fop = 2'b00; imm = '0; c_we = 0; z_we = 0; rs_we = 0; irq = 0; iend = 0;
  endtask

  // inputs driven at negedge, result checked at next negedge
  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic op(input logic [1:0] o, input logic [7:0] v);
    fop = o; imm = v; cyc(); idle();
  endtask

  task automatic restore(input logic [7:0] v);
    rs_we = 1; rs_v = v; cyc(); idle();
  endtask

  task automatic t_reset();
    chk("R1 flags", flags, 8'h02);
    chk("R1 take", {7'b0, take}, 8'h00);
    chk("R1 bank", {7'b0, bank}, 8'h00);
    chk("R1 page", {6'b0, pg}, 8'h00);
  endtask

  task automatic t_ops();
    op(2'b10, 8'hFF);
    chk("R2 OR / R3 mask", flags, 8'hD7);
    chk("R11 bank", {7'b0, bank}, 8'h01);
    chk("R11 page", {6'b0, pg}, 8'h03);
    op(2'b01, 8'hB0);
    chk("R2 AND", flags, 8'h90);
    op(2'b11, 8'h7D);
    chk("R2 XOR / R3 mask", flags, 8'hC5);
    chk("R11 page after XOR", {6'b0, pg}, 8'h03);
    op(2'b00, 8'h00);
    chk("R2 none", flags, 8'hC5);
  endtask

  task automatic t_alu();
    c_we = 1; c_v = 0; cyc(); idle();
    chk("R4 carry clear", flags, 8'hC1);
    z_we = 1; z_v = 1; c_v = 1; cyc(); idle();
    chk("R4 zero set only", flags, 8'hC3);
    c_we = 1; c_v = 1; z_we = 1; z_v = 0; cyc(); idle();
    chk("R4 both", flags, 8'hC5);
    fop = 2'b01; imm = 8'hF0; c_we = 1; c_v = 1; z_we = 1; z_v = 1; cyc(); idle();
    chk("R5 op beats alu", flags, 8'hC0);
  endtask

  task automatic t_restore();
    restore(8'hFF);
    chk("R9 restore masked", flags, 8'hD7);
    rs_we = 1; rs_v = 8'h42; fop = 2'b10; imm = 8'h01; c_we = 1; c_v = 1; cyc(); idle();
    chk("R9 restore beats op", flags, 8'h42);
  endtask

  task automatic t_read();
    restore(8'hFF);
    rd_en = 1; rd_addr = 8'hF7; #1;
    chk("R10 hit bank1", {7'b0, rd_hit}, 8'h01);
    chk("R10 data bank1 / R3", rd_data, 8'hD7);
    restore(8'h06);
    rd_en = 1; rd_addr = 8'hF7; #1;
    chk("R10 data bank0", rd_data, 8'h06);
    rd_addr = 8'hF6; #1;
    chk("R10 miss hit", {7'b0, rd_hit}, 8'h00);
    chk("R10 miss data", rd_data, 8'h00);
    rd_addr = 8'hF7; rd_en = 0; #1;
    chk("R10 disabled", rd_data, 8'h00);
  endtask

  task automatic t_irq();
    restore(8'h13);
    irq = 1; iend = 0; cyc(); idle();
    chk("R7 no boundary", {7'b0, take}, 8'h00);
    chk("R7 gie kept", flags, 8'h13);
    irq = 1; iend = 1; cyc(); idle();
    chk("R6 take", {7'b0, take}, 8'h01);
    chk("R6 stacked", stk, 8'h13);
    chk("R6 gie cleared", flags, 8'h12);
    cyc();
    chk("R6 single pulse", {7'b0, take}, 8'h00);
    irq = 1; iend = 1; cyc(); idle();
    chk("R7 gie off ignored", {7'b0, take}, 8'h00);
    chk("R7 stack held", stk, 8'h13);
    restore(8'h01);
    irq = 1; iend = 1; fop = 2'b10; imm = 8'h04; c_we = 1; c_v = 1; cyc(); idle();
    chk("R8 take beats op", flags, 8'h00);
    chk("R8 stacked", stk, 8'h01);
    restore(8'hC1);
    irq = 1; iend = 1; rs_we = 1; rs_v = 8'h55; cyc(); idle();
    chk("R8 take beats restore", flags, 8'hC0);
  endtask

  initial begin
    fork
      begin
        #5 rst_n = 0;
        @(negedge clk); @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_ops();
        t_alu();
        t_restore();
        t_read();
        t_irq();
      end
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule